// File: doc/BRIEF.md
# USB Host IN-Transaction Receive Checker

This block sits on the host side of a USB IN transaction and takes over as soon as the IN token has left the host. Once a start pulse arrives, it watches a decoded bit stream, one bit per strobe, for a data packet. A response window limits how long it waits. The first byte that forms a valid DATA0 or DATA1 packet identifier opens the data phase. Bytes that do not qualify are dropped, and the block keeps listening.

During the data phase the block drops the zero that follows every six consecutive ones. It runs a serial CRC16 over the remaining bits and passes them on as a byte stream. When the end-of-packet strobe arrives it judges the packet. The judgement covers CRC, whole-octet length and stuffing, and it yields a set of status flags, the received PID and a one-cycle completion pulse.

That pulse comes with a handshake decision. The host either sends ACK or stays silent. The pulse also carries either an error interrupt or, when enabled, a completion interrupt. After the pulse the block returns to idle.

Top module: `usbh_in_rx`

## Requirements
- R1: If no valid data PID has been accepted TIMEOUT_BITS*CLKS_PER_BIT clock cycles after the start pulse is sampled, the done pulse appears on the cycle after that count. It carries the timeout flag and the error interrupt, and no ACK.
- R2: Bits arrive LSB first. A received byte is accepted as a PID only if its upper nibble is the bitwise inverse of its lower nibble and the lower nibble is 0011 (DATA0) or 1011 (DATA1). Any other byte is discarded and the wait continues. The accepted lower nibble appears on pid_o.
- R3: After six consecutive ones on the raw stream, the next bit is removed, so it is neither counted nor placed in the byte stream.
- R4: A one arriving where a stuffed zero is due, which is the seventh consecutive one, sets the stuff-error flag for the packet.
- R5: The CRC register uses x^16+x^15+x^2+1, is preset to all ones when the PID is accepted, and advances on every data-phase bit. At end of packet any residual other than 0x800D sets the CRC-error flag.
- R6: At end of packet, a data-phase bit count that is not a multiple of eight sets the non-octet flag.
- R7: The receive-error flag is set exactly when the CRC-error, non-octet or stuff-error flag is set. The error interrupt fires with the done pulse whenever the receive-error flag or the timeout flag is set.
- R8: The completion interrupt fires with the done pulse only when no error flag is set and int_en_i was high at the start pulse.
- R9: ACK is raised with the done pulse only when the packet arrived intact. A corrupted or missing packet gets no handshake.
- R10: busy_o rises on the cycle after a start pulse accepted in idle and falls together with a single-cycle done pulse. The block is then idle, and the status flags hold until the next start.
- R11: Every eight data-phase bits, the trailing CRC bytes included, are delivered LSB first on byte_o with a one-cycle byte_vld_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse: IN token has been sent |
| int_en_i | input | 1 | Completion interrupt enable, sampled with start_i |
| bit_vld_i | input | 1 | Strobe for one decoded line bit |
| bit_i | input | 1 | Decoded line bit value |
| eop_i | input | 1 | End-of-packet strobe |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ack_o | output | 1 | Send ACK handshake (valid with done_o) |
| err_irq_o | output | 1 | Error interrupt pulse |
| cmp_irq_o | output | 1 | Completion interrupt pulse |
| sts_timeout_o | output | 1 | No data packet in the response window |
| sts_crc_o | output | 1 | CRC mismatch |
| sts_nonoct_o | output | 1 | Data field not a whole number of octets |
| sts_stuff_o | output | 1 | Bit-stuffing violation |
| sts_rxerr_o | output | 1 | Summary receive error |
| pid_o | output | 4 | Accepted data PID, lower nibble |
| byte_o | output | 8 | Received byte |
| byte_vld_o | output | 1 | byte_o valid |

## Verification
The bench builds the block with CLKS_PER_BIT set to 1 and TIMEOUT_BITS kept at 18. With those values one bit arrives per clock, so the timeout lands on an exact, countable cycle. Every one of the 256 possible first bytes can then be swept as a PID candidate within a few thousand cycles. Payloads of zero to four bytes, all-ones bytes that force stuffing, single-bit corruption, one to seven trailing extra bits and a raw seven-ones run cover every flag combination. Expected CRCs and byte groupings are computed arithmetically in the bench.

// File: rtl/usbh_in_pkg.sv
package usbh_in_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DATA = 2'd2,
    ST_DONE = 2'd3
  } rx_state_e;

  localparam logic [15:0] CRC_POLY     = 16'h8005;
  localparam logic [15:0] CRC_RESIDUAL = 16'h800D;
  localparam logic [2:0]  PID_DATA_LSB = 3'b011;
endpackage

// File: rtl/usbh_in_unstuff.sv
module usbh_in_unstuff #(
  parameter int unsigned RUN_LEN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic bit_vld_i,
  input  logic bit_i,
  output logic dat_vld_o,
  output logic dat_o,
  output logic viol_o
);
  localparam int unsigned OW = $clog2(RUN_LEN + 1);

  logic [OW-1:0] ones_q, ones_d;
  logic          slot;

  assign slot      = (ones_q == OW'(RUN_LEN));
  assign dat_vld_o = bit_vld_i && !slot;
  assign dat_o     = bit_i;
  assign viol_o    = bit_vld_i && slot && bit_i;

  always_comb begin
    ones_d = ones_q;
    if (clr_i) begin
      ones_d = '0;
    end else if (bit_vld_i) begin
      if (slot || !bit_i) ones_d = '0;
      else                ones_d = ones_q + OW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ones_q <= '0;
    else        ones_q <= ones_d;
  end

  // R4
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= OW'(RUN_LEN));

  // R3
  stuff_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld_i && slot) |=> (ones_q == '0));
endmodule

// File: rtl/usbh_in_crc16.sv
module usbh_in_crc16
  import usbh_in_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic        din_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q, crc_d;
  logic        fb;

  assign fb    = din_i ^ crc_q[15];
  assign crc_o = crc_q;

  always_comb begin
    crc_d = crc_q;
    if (clr_i)     crc_d = '1;
    else if (en_i) crc_d = {crc_q[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '1;
    else        crc_q <= crc_d;
  end

  // R5
  preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (crc_o == 16'hFFFF));
endmodule

// File: rtl/usbh_in_rx.sv
module usbh_in_rx
  import usbh_in_pkg::*;
#(
  parameter int unsigned TIMEOUT_BITS = 18,
  parameter int unsigned CLKS_PER_BIT = 4,
  parameter int unsigned RUN_LEN      = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       int_en_i,
  input  logic       bit_vld_i,
  input  logic       bit_i,
  input  logic       eop_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       ack_o,
  output logic       err_irq_o,
  output logic       cmp_irq_o,
  output logic       sts_timeout_o,
  output logic       sts_crc_o,
  output logic       sts_nonoct_o,
  output logic       sts_stuff_o,
  output logic       sts_rxerr_o,
  output logic [3:0] pid_o,
  output logic [7:0] byte_o,
  output logic       byte_vld_o
);
  localparam int unsigned LIMIT = TIMEOUT_BITS * CLKS_PER_BIT;
  localparam int unsigned TW    = $clog2(LIMIT + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_nq;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_nq = rst_pipe[1];

  rx_state_e   state_q, state_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [2:0]  cnt_q, cnt_d;
  logic [7:0]  sh_q, sh_d;
  logic        bvld_q, bvld_d;
  logic        busy_q, busy_d;
  logic        ien_q, ien_d;
  logic        tmo_q, tmo_d;
  logic        crc_q, crc_d;
  logic        non_q, non_d;
  logic        stf_q, stf_d;
  logic        rxe_q, rxe_d;
  logic [3:0]  pid_q, pid_d;

  logic        ds_vld, ds_bit, ds_viol, us_clr;
  logic        crc_clr, crc_en;
  logic [15:0] crc_val;
  logic [7:0]  cand;
  logic        pid_ok, tmr_end;

  assign us_clr = (state_q == ST_IDLE) || eop_i;

  usbh_in_unstuff #(.RUN_LEN(RUN_LEN)) u_unstuff (
    .clk       (clk),
    .rst_n     (rst_nq),
    .clr_i     (us_clr),
    .bit_vld_i (bit_vld_i),
    .bit_i     (bit_i),
    .dat_vld_o (ds_vld),
    .dat_o     (ds_bit),
    .viol_o    (ds_viol)
  );

  assign cand    = {ds_bit, sh_q[7:1]};
  assign pid_ok  = (state_q == ST_WAIT) && ds_vld && !eop_i && (cnt_q == 3'd7) &&
                   (cand[7:4] == ~cand[3:0]) && (cand[2:0] == PID_DATA_LSB);
  assign tmr_end = (tmr_q == TW'(LIMIT - 1));
  assign crc_clr = pid_ok;
  assign crc_en  = (state_q == ST_DATA) && ds_vld && !eop_i;

  usbh_in_crc16 u_crc (
    .clk   (clk),
    .rst_n (rst_nq),
    .clr_i (crc_clr),
    .en_i  (crc_en),
    .din_i (ds_bit),
    .crc_o (crc_val)
  );

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    bvld_d  = 1'b0;
    busy_d  = busy_q;
    ien_d   = ien_q;
    tmo_d   = tmo_q;
    crc_d   = crc_q;
    non_d   = non_q;
    stf_d   = stf_q;
    rxe_d   = rxe_q;
    pid_d   = pid_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_WAIT;
          tmr_d   = '0;
          cnt_d   = '0;
          busy_d  = 1'b1;
          ien_d   = int_en_i;
          tmo_d   = 1'b0;
          crc_d   = 1'b0;
          non_d   = 1'b0;
          stf_d   = 1'b0;
          rxe_d   = 1'b0;
          pid_d   = '0;
        end
      end
      ST_WAIT: begin
        if (pid_ok) begin
          state_d = ST_DATA;
          pid_d   = cand[3:0];
          cnt_d   = '0;
        end else if (tmr_end) begin
          state_d = ST_DONE;
          tmo_d   = 1'b1;
          busy_d  = 1'b0;
        end else begin
          tmr_d = tmr_q + TW'(1);
          if (eop_i) begin
            cnt_d = '0;
          end else if (ds_vld) begin
            cnt_d = cnt_q + 3'd1;
            sh_d  = cand;
          end
        end
      end
      ST_DATA: begin
        if (eop_i) begin
          state_d = ST_DONE;
          busy_d  = 1'b0;
          crc_d   = (crc_val != CRC_RESIDUAL);
          non_d   = (cnt_q != 3'd0);
          rxe_d   = (crc_val != CRC_RESIDUAL) || (cnt_q != 3'd0) || stf_q;
        end else begin
          if (ds_viol) stf_d = 1'b1;
          if (ds_vld) begin
            cnt_d  = cnt_q + 3'd1;
            sh_d   = cand;
            bvld_d = (cnt_q == 3'd7);
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_nq) begin
    if (!rst_nq) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      cnt_q   <= '0;
      sh_q    <= '0;
      bvld_q  <= 1'b0;
      busy_q  <= 1'b0;
      ien_q   <= 1'b0;
      tmo_q   <= 1'b0;
      crc_q   <= 1'b0;
      non_q   <= 1'b0;
      stf_q   <= 1'b0;
      rxe_q   <= 1'b0;
      pid_q   <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      bvld_q  <= bvld_d;
      busy_q  <= busy_d;
      ien_q   <= ien_d;
      tmo_q   <= tmo_d;
      crc_q   <= crc_d;
      non_q   <= non_d;
      stf_q   <= stf_d;
      rxe_q   <= rxe_d;
      pid_q   <= pid_d;
    end
  end

  logic any_err;
  assign any_err       = tmo_q || rxe_q;
  assign done_o        = (state_q == ST_DONE);
  assign ack_o         = done_o && !any_err;
  assign err_irq_o     = done_o && any_err;
  assign cmp_irq_o     = done_o && !any_err && ien_q;
  assign busy_o        = busy_q;
  assign sts_timeout_o = tmo_q;
  assign sts_crc_o     = crc_q;
  assign sts_nonoct_o  = non_q;
  assign sts_stuff_o   = stf_q;
  assign sts_rxerr_o   = rxe_q;
  assign pid_o         = pid_q;
  assign byte_o        = sh_q;
  assign byte_vld_o    = bvld_q;

  // R9
  ack_clean_chk: assert property (@(posedge clk) disable iff (!rst_nq)
    ack_o |-> (!err_irq_o && !sts_timeout_o && !sts_rxerr_o));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_nq)
    done_o |=> (!done_o && !busy_o));

  // R8
  cmp_gate_chk: assert property (@(posedge clk) disable iff (!rst_nq)
    cmp_irq_o |-> ack_o);

  // R1
  tmo_irq_chk: assert property (@(posedge clk) disable iff (!rst_nq)
    (done_o && sts_timeout_o) |-> (err_irq_o && !ack_o));

  // R7
  rxerr_sum_chk: assert property (@(posedge clk) disable iff (!rst_nq)
    (done_o && (sts_crc_o || sts_nonoct_o || sts_stuff_o)) |-> (sts_rxerr_o && err_irq_o));

  // R11
  byte_in_txn_chk: assert property (@(posedge clk) disable iff (!rst_nq)
    byte_vld_o |-> busy_o);
endmodule

// File: tb/usbh_in_rx_tb.sv
`timescale 1ns/1ps
module usbh_in_rx_tb;
  localparam int TMO = 18;

  logic clk = 1'b0;
  logic rst_n, start, ien, bv, bi, eop;
  logic busy_o, done_o, ack_o, err_irq_o, cmp_irq_o;
  logic sts_timeout_o, sts_crc_o, sts_nonoct_o, sts_stuff_o, sts_rxerr_o;
  logic [3:0] pid_o;
  logic [7:0] byte_o;
  logic byte_vld_o;

  always #10 clk = ~clk;

  usbh_in_rx #(.TIMEOUT_BITS(TMO), .CLKS_PER_BIT(1), .RUN_LEN(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .int_en_i(ien),
    .bit_vld_i(bv), .bit_i(bi), .eop_i(eop),
    .busy_o(busy_o), .done_o(done_o), .ack_o(ack_o), .err_irq_o(err_irq_o),
    .cmp_irq_o(cmp_irq_o), .sts_timeout_o(sts_timeout_o), .sts_crc_o(sts_crc_o),
    .sts_nonoct_o(sts_nonoct_o), .sts_stuff_o(sts_stuff_o), .sts_rxerr_o(sts_rxerr_o),
    .pid_o(pid_o), .byte_o(byte_o), .byte_vld_o(byte_vld_o)
  );

  int n_chk = 0;
  int n_err = 0;
  int ones = 0;
  int nrx = 0;
  bit got_done = 0;
  int n_done = 0;
  logic d_ack, d_err, d_cmp, d_tmo, d_crc, d_non, d_stf, d_rxe;
  logic [3:0] d_pid;
  logic [7:0] rx_bytes [0:31];
  bit exp_bits [0:511];
  int nb = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (byte_vld_o && nrx < 32) begin
      rx_bytes[nrx] = byte_o;
      nrx++;
    end
    if (done_o) begin
      got_done = 1;
      n_done++;
      d_ack = ack_o; d_err = err_irq_o; d_cmp = cmp_irq_o; d_tmo = sts_timeout_o;
      d_crc = sts_crc_o; d_non = sts_nonoct_o; d_stf = sts_stuff_o; d_rxe = sts_rxerr_o;
      d_pid = pid_o;
    end
  end

  function automatic logic [15:0] crc_step(logic [15:0] c, bit b);
    logic fb;
    fb = b ^ c[15];
    c = {c[14:0], 1'b0};
    if (fb) c = c ^ 16'h8005;
    return c;
  endfunction

  function automatic logic [7:0] pat(int len, int i);
    if (len == 3) return 8'hFF;
    return 8'((len * 53 + i * 29 + 7) & 255);
  endfunction

  task automatic tx_raw(bit b);
    @(negedge clk);
    bv = 1'b1; bi = b;
    ones = b ? ones + 1 : 0;
  endtask

  task automatic tx_bit(bit b, bit rec);
    tx_raw(b);
    if (rec) begin exp_bits[nb] = b; nb++; end
    if (ones == 6) tx_raw(1'b0);
  endtask

  task automatic tx_byte(logic [7:0] v, bit rec);
    for (int i = 0; i < 8; i++) tx_bit(v[i], rec);
  endtask

  task automatic tx_eop();
    @(negedge clk); bv = 1'b0; eop = 1'b1;
    @(negedge clk); eop = 1'b0;
  endtask

  task automatic begin_txn(bit ie);
    @(negedge clk);
    nrx = 0; got_done = 0; nb = 0; ones = 0;
    start = 1'b1; ien = ie;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int k);
    k = 0;
    #1;
    while (!got_done && k < 300) begin
      @(negedge clk); #1; k++;
    end
  endtask

  // sends PID, payload, CRC, optional extra bits; flips one payload bit when corrupt
  task automatic send_pkt(logic [3:0] pid, int len, bit ie, bit corrupt, int extra, bit junk);
    logic [15:0] c;
    logic [7:0] d;
    int k;
    begin_txn(ie);
    if (junk) tx_byte(8'h00, 0);
    tx_byte({~pid, pid}, 0);
    c = 16'hFFFF;
    for (int i = 0; i < len; i++) begin
      d = pat(len, i);
      for (int j = 0; j < 8; j++) c = crc_step(c, d[j]);
      if (corrupt && i == 0) d[0] = ~d[0];
      tx_byte(d, 1);
    end
    for (int j = 15; j >= 0; j--) tx_bit(~c[j], 1);
    for (int j = 0; j < extra; j++) tx_bit(1'b0, 1);
    tx_eop();
    wait_done(k);
    chk("R10 done seen", int'(got_done), 1);
  endtask

  task automatic check_bytes(string tag);
    logic [7:0] e;
    chk({tag, " byte count"}, nrx, nb / 8);
    for (int i = 0; i < nb / 8 && i < nrx; i++) begin
      for (int j = 0; j < 8; j++) e[j] = exp_bits[i * 8 + j];
      chk({tag, " byte value"}, int'(rx_bytes[i]), int'(e));
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
      end
    end
  end

  initial begin
    int k;
    bit valid;
    logic [7:0] b;
    rst_n = 1'b0; start = 1'b0; ien = 1'b0; bv = 1'b0; bi = 1'b0; eop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 reset busy", int'(busy_o), 0);
    chk("R10 reset done", int'(done_o), 0);
    chk("R9 reset ack", int'(ack_o), 0);

    // R1: exact timeout with no traffic
    begin_txn(1);
    chk("R10 busy after start", int'(busy_o), 1);
    wait_done(k);
    chk("R1 timeout cycle", k, TMO);
    chk("R1 timeout flag", int'(d_tmo), 1);
    chk("R1 error irq", int'(d_err), 1);
    chk("R9 no ack on timeout", int'(d_ack), 0);
    chk("R8 no cmp on timeout", int'(d_cmp), 0);
    chk("R10 one done pulse", n_done, 1);
    @(negedge clk);
    chk("R10 idle after done", int'(busy_o), 0);
    chk("R10 status held", int'(sts_timeout_o), 1);

    // R2: every possible first byte followed by end of packet
    for (int v = 0; v < 256; v++) begin
      b = 8'(v);
      valid = (b[7:4] == ~b[3:0]) && (b[2:0] == 3'b011);
      begin_txn(0);
      tx_byte(b, 0);
      tx_eop();
      wait_done(k);
      if (valid) begin
        chk("R2 accepted no timeout", int'(d_tmo), 0);
        chk("R2 pid latched", int'(d_pid), int'(b[3:0]));
        chk("R5 empty residual mismatch", int'(d_crc), 1);
      end else begin
        chk("R2 ignored byte times out", int'(d_tmo), 1);
        chk("R9 ignored byte no ack", int'(d_ack), 0);
      end
      @(negedge clk);
    end

    // R2: junk byte first, then a valid packet
    send_pkt(4'b1011, 2, 1, 0, 0, 1);
    chk("R2 after junk accepted", int'(d_ack), 1);
    chk("R2 after junk pid", int'(d_pid), 11);
    check_bytes("R11 after junk");

    // R3 R5 R8 R9 R11: clean packets of several lengths, both PIDs
    for (int len = 0; len <= 4; len++) begin
      for (int p = 0; p < 2; p++) begin
        send_pkt(p ? 4'b1011 : 4'b0011, len, len[0], 0, 0, 0);
        chk("R9 ack clean", int'(d_ack), 1);
        chk("R7 no error irq", int'(d_err), 0);
        chk("R5 crc ok", int'(d_crc), 0);
        chk("R6 octet ok", int'(d_non), 0);
        chk("R8 cmp follows enable", int'(d_cmp), len % 2);
        chk("R2 pid", int'(d_pid), p ? 11 : 3);
        check_bytes(len == 3 ? "R3 stuffed ones" : "R11 clean");
        @(negedge clk);
      end
    end

    // R5 R7: corrupted payload bit
    send_pkt(4'b0011, 2, 1, 1, 0, 0);
    chk("R5 crc error", int'(d_crc), 1);
    chk("R7 rxerr", int'(d_rxe), 1);
    chk("R7 error irq", int'(d_err), 1);
    chk("R9 no ack corrupt", int'(d_ack), 0);
    chk("R8 no cmp corrupt", int'(d_cmp), 0);

    // R6: trailing partial byte of 1..7 bits
    for (int x = 1; x < 8; x++) begin
      send_pkt(4'b1011, 1, 1, 0, x, 0);
      chk("R6 nonoct flag", int'(d_non), 1);
      chk("R7 rxerr nonoct", int'(d_rxe), 1);
      chk("R9 no ack nonoct", int'(d_ack), 0);
      check_bytes("R11 nonoct");
    end

    // R4: seven raw ones after a valid PID
    begin_txn(1);
    tx_byte(8'hC3, 0);
    for (int i = 0; i < 7; i++) tx_raw(1'b1);
    tx_eop();
    wait_done(k);
    chk("R4 stuff flag", int'(d_stf), 1);
    chk("R7 rxerr stuff", int'(d_rxe), 1);
    chk("R7 err irq stuff", int'(d_err), 1);
    chk("R9 no ack stuff", int'(d_ack), 0);
    chk("R1 no timeout stuff", int'(d_tmo), 0);

    // R4: exactly six ones followed by the stuffed zero is clean
    send_pkt(4'b0011, 3, 0, 0, 0, 0);
    chk("R4 legal stuffing", int'(d_stf), 0);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule